// File: doc/BRIEF.md
# Conditional Transfer Sequencer

This block carries out the three conditional control transfers of a processor with a 32-bit program counter: a jump to an effective address, a call that saves the return address on the stack before jumping, and a return that restores the program counter from the stack. One operation is offered on an input stream together with a 4-bit condition code, the four arithmetic flags, the effective address, the sequential next PC and the current stack pointer. The block decides whether the condition holds. For a taken call or return it moves the 32-bit PC through a byte-wide stack memory port. It then presents the new PC, the new stack pointer, the taken decision and the cycle cost on an output stream.

Taken and not-taken outcomes cost different numbers of cycles: 9 for a taken jump, 12 for a taken call or return, and 6 for any operation that is not taken. The result never appears earlier than that cost allows. If the stack memory stalls, the result waits until the last stack byte has been moved. Both streams use valid/ready. An operation is accepted on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` stays low from acceptance until the result has been taken. A result is presented with `res_valid` and is held unchanged until `res_ready` is high. On the stack port, a request holds all its fields while `mem_req_ready` is low. Read data comes back in order on `mem_rsp_valid`, one clock edge or later after the request, and cannot be back-pressured.

Top module: `ctlx_seq`

## Requirements
- R1: During and right after reset, `op_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: The condition code `op_cc` selects a test on the flags `op_flags` = {S,Z,V,C} (bit 3 = S, bit 2 = Z, bit 1 = V, bit 0 = C). The codes are: 0 never, 1 S^V, 2 (S^V)|Z, 3 C|Z, 4 V, 5 S, 6 Z, 7 C. Codes 8 to 15 are the complements of codes 0 to 7 (8 always, 9 !(S^V), 10 !((S^V)|Z), 11 !(C|Z), 12 !V, 13 !S, 14 !Z, 15 !C).
- R3: A taken jump (`op_kind` = 2'b00) gives `res_pc` = `op_ea` and leaves `res_sp` = `op_sp`. It makes no stack access and reports a cost of 9.
- R4: A not-taken operation gives `res_pc` = `op_seq_pc`, `res_sp` = `op_sp` and `res_taken` = 0. It makes no stack access and reports a cost of 6.
- R5: A taken call (`op_kind` = 2'b01) writes `op_seq_pc` as four bytes, least significant byte first, to addresses `op_sp`-4 up to `op_sp`-1. It then gives `res_sp` = `op_sp`-4 and `res_pc` = `op_ea`, and reports a cost of 12.
- R6: A taken return (`op_kind` = 2'b10) reads the four bytes at `op_sp` up to `op_sp`+3 and assembles them least significant byte first into `res_pc`. It gives `res_sp` = `op_sp`+4 and reports a cost of 12.
- R7: With no stack stalls, `res_valid` first goes high on the clock edge that lies exactly cost edges after the accepting edge. `res_valid` is never high earlier than that, and never while stack transfers are still pending.
- R8: The operation fields are captured at acceptance. Changing them while the block is busy has no effect on the result, and `op_ready` stays low until the result is taken.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_pc`, `res_sp`, `res_taken` and `res_cycles` stay unchanged.
- R10: A stack request keeps its address, data and direction while `mem_req_ready` is low. Read responses are accepted only while a return is waiting for them.
- R11: The reserved operation code 2'b11 is never taken, whatever the condition, and behaves as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block can accept an operation |
| op_kind | input | 2 | 00 jump, 01 call, 10 return, 11 reserved |
| op_cc | input | 4 | Condition code |
| op_flags | input | 4 | Flags {S,Z,V,C} |
| op_ea | input | 32 | Effective address (target) |
| op_seq_pc | input | 32 | Sequential next PC (also the return address) |
| op_sp | input | 32 | Current stack pointer |
| res_valid | output | 1 | Result presented |
| res_ready | input | 1 | Consumer takes the result |
| res_pc | output | 32 | Next PC |
| res_sp | output | 32 | Updated stack pointer |
| res_taken | output | 1 | Condition held |
| res_cycles | output | 4 | Cycle cost of the operation |
| mem_req_valid | output | 1 | Stack byte request |
| mem_req_ready | input | 1 | Stack memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read byte returned |
| mem_rdata | input | 8 | Returned byte |

## Verification
Two things can land on the same clock edge: the end of the cycle budget and the last stack byte transfer of a call or return. The bench drives the stack port with randomly withheld `mem_req_ready`. Depending on the stalls, the fourth byte then finishes before, on, or after the budget edge. A reference model written in the bench decides the outcome and is checked every clock. The result must never appear before the cost and never while stack traffic is still pending, and its PC, SP and stored bytes must match the model whichever event came last.

// File: rtl/ctlx_pkg.sv
`timescale 1ns/1ps
package ctlx_pkg;
  typedef enum logic [1:0] {
    XK_JUMP = 2'b00,
    XK_CALL = 2'b01,
    XK_RET  = 2'b10,
    XK_RSVD = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_RESP = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic s;
    logic z;
    logic v;
    logic c;
  } flag_t;
endpackage

// File: rtl/ctlx_cond_eval.sv
`timescale 1ns/1ps
module ctlx_cond_eval
  import ctlx_pkg::*;
(
  input  logic [3:0] cc,
  input  flag_t      fl,
  output logic       take
);
  logic base;

  always_comb begin
    unique case (cc[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = fl.s ^ fl.v;
      3'd2:    base = (fl.s ^ fl.v) | fl.z;
      3'd3:    base = fl.c | fl.z;
      3'd4:    base = fl.v;
      3'd5:    base = fl.s;
      3'd6:    base = fl.z;
      default: base = fl.c;
    endcase
    take = base ^ cc[3];
  end

  always_comb begin
    // R2
    if (cc == 4'h8) begin
      always_code_chk: assert (take);
    end
    // R2
    if (cc == 4'h0) begin
      never_code_chk: assert (!take);
    end
  end
endmodule

// File: rtl/ctlx_budget_timer.sv
`timescale 1ns/1ps
module ctlx_budget_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val - CW'(1);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);

  // R7
  budget_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val > CW'(1)) |=> !expired);
endmodule

// File: rtl/ctlx_stack_mover.sv
`timescale 1ns/1ps
module ctlx_stack_mover #(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            push,
  input  logic [AW-1:0]   base,
  input  logic [NB*8-1:0] wdata,
  output logic            busy,
  output logic [NB*8-1:0] rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [AW-1:0]   mem_req_addr,
  output logic [7:0]      mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [7:0]      mem_rdata
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] NB_C   = CW'(NB);
  localparam logic [CW-1:0] LAST_C = CW'(NB - 1);

  logic [CW-1:0]   iss_cnt, rsp_cnt;
  logic [IW-1:0]   iss_idx, rsp_idx;
  logic [AW-1:0]   base_q;
  logic [NB*8-1:0] wbuf;
  logic            push_q;
  logic            hs, rsp_take, last_done;

  assign iss_idx       = iss_cnt[IW-1:0];
  assign rsp_idx       = rsp_cnt[IW-1:0];
  assign mem_req_valid = busy && (iss_cnt != NB_C);
  assign mem_req_we    = push_q;
  assign mem_req_addr  = base_q + AW'(iss_cnt);
  assign mem_req_wdata = wbuf[8*iss_idx +: 8];
  assign hs            = mem_req_valid && mem_req_ready;
  assign rsp_take      = busy && !push_q && mem_rsp_valid;
  assign last_done     = push_q ? (hs && iss_cnt == LAST_C)
                                : (rsp_take && rsp_cnt == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      iss_cnt <= '0;
      rsp_cnt <= '0;
      base_q  <= '0;
      push_q  <= 1'b0;
      wbuf    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      iss_cnt <= '0;
      rsp_cnt <= '0;
      base_q  <= base;
      push_q  <= push;
      wbuf    <= wdata;
    end else if (busy) begin
      if (hs)        iss_cnt <= iss_cnt + CW'(1);
      if (rsp_take)  rsp_cnt <= rsp_cnt + CW'(1);
      if (last_done) busy    <= 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_rbyte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata[8*b +: 8] <= '0;
      else if (rsp_take && rsp_idx == IW'(b))
        rdata[8*b +: 8] <= mem_rdata;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_we));

  // R10
  rsp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> busy && !push_q);
endmodule

// File: rtl/ctlx_seq.sv
`timescale 1ns/1ps
module ctlx_seq
  import ctlx_pkg::*;
#(
  parameter int AW             = 32,
  parameter int CNT_W          = 4,
  parameter int CYC_JUMP_TAKEN = 9,
  parameter int CYC_CALL_TAKEN = 12,
  parameter int CYC_RET_TAKEN  = 12,
  parameter int CYC_NOT_TAKEN  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_kind,
  input  logic [3:0]       op_cc,
  input  logic [3:0]       op_flags,
  input  logic [AW-1:0]    op_ea,
  input  logic [AW-1:0]    op_seq_pc,
  input  logic [AW-1:0]    op_sp,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [AW-1:0]    res_pc,
  output logic [AW-1:0]    res_sp,
  output logic             res_taken,
  output logic [CNT_W-1:0] res_cycles,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic [7:0]       mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rdata
);
  localparam int NB = AW / 8;
  localparam logic [AW-1:0] STEP = AW'(NB);

  seq_state_e       state;
  xfer_kind_e       kind_in, k_q;
  logic             cond_ok, taken_in, taken_q, accept, stk_start, finish;
  logic [CNT_W-1:0] cost_in, cost_q;
  logic [AW-1:0]    ea_q, seq_q, sp_q, stk_base;
  logic [AW-1:0]    stk_rdata;
  logic             stk_busy, expired;

  assign kind_in  = xfer_kind_e'(op_kind);
  assign op_ready = (state == SQ_IDLE);
  assign accept   = op_valid && op_ready;

  ctlx_cond_eval u_cond (
    .cc   (op_cc),
    .fl   (flag_t'(op_flags)),
    .take (cond_ok)
  );

  assign taken_in = cond_ok && (kind_in != XK_RSVD);

  always_comb begin
    if (!taken_in) cost_in = CNT_W'(CYC_NOT_TAKEN);
    else begin
      unique case (kind_in)
        XK_CALL: cost_in = CNT_W'(CYC_CALL_TAKEN);
        XK_RET:  cost_in = CNT_W'(CYC_RET_TAKEN);
        default: cost_in = CNT_W'(CYC_JUMP_TAKEN);
      endcase
    end
  end

  assign stk_start = accept && taken_in && (kind_in == XK_CALL || kind_in == XK_RET);
  assign stk_base  = (kind_in == XK_CALL) ? (op_sp - STEP) : op_sp;

  ctlx_budget_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cost_in),
    .expired  (expired)
  );

  ctlx_stack_mover #(.AW(AW), .NB(NB)) u_stack (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (stk_start),
    .push          (kind_in == XK_CALL),
    .base          (stk_base),
    .wdata         (op_seq_pc),
    .busy          (stk_busy),
    .rdata         (stk_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rdata     (mem_rdata)
  );

  assign finish = (state == SQ_BUSY) && expired && !stk_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      k_q     <= XK_JUMP;
      taken_q <= 1'b0;
      cost_q  <= '0;
      ea_q    <= '0;
      seq_q   <= '0;
      sp_q    <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (accept) begin
          state   <= SQ_BUSY;
          k_q     <= kind_in;
          taken_q <= taken_in;
          cost_q  <= cost_in;
          ea_q    <= op_ea;
          seq_q   <= op_seq_pc;
          sp_q    <= op_sp;
        end
        SQ_BUSY: if (finish) state <= SQ_RESP;
        default: if (res_ready) state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    res_pc = seq_q;
    res_sp = sp_q;
    if (taken_q) begin
      unique case (k_q)
        XK_JUMP: res_pc = ea_q;
        XK_CALL: begin res_pc = ea_q;      res_sp = sp_q - STEP; end
        XK_RET:  begin res_pc = stk_rdata; res_sp = sp_q + STEP; end
        default: ;
      endcase
    end
  end

  assign res_valid  = (state == SQ_RESP);
  assign res_taken  = taken_q;
  assign res_cycles = cost_q;

  // R4
  quiet_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BUSY) && (!taken_q || k_q == XK_JUMP || k_q == XK_RSVD) |-> !mem_req_valid);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=>
      res_valid && $stable(res_pc) && $stable(res_sp) && $stable(res_taken) && $stable(res_cycles));

  // R5
  push_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> (sp_q - mem_req_addr - AW'(1)) < STEP);

  // R6
  pop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> (mem_req_addr - sp_q) < STEP);

  // R7
  no_early_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_busy |-> !res_valid);
endmodule

// File: tb/tb_ctlx_seq.sv
`timescale 1ns/1ps
module tb_ctlx_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_kind = '0;
  logic [3:0]  op_cc = '0;
  logic [3:0]  op_flags = '0;
  logic [31:0] op_ea = '0, op_seq_pc = '0, op_sp = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_pc, res_sp;
  logic        res_taken;
  logic [3:0]  res_cycles;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        rsp_v = 1'b0;
  logic [7:0]  rsp_d = '0;

  int  n_chk = 0, n_err = 0, wr_cnt = 0;
  bit  stall_mode = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] smem [int unsigned];

  always #2.5 clk = ~clk;

  ctlx_seq dut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_cc(op_cc),
    .op_flags(op_flags), .op_ea(op_ea), .op_seq_pc(op_seq_pc), .op_sp(op_sp),
    .res_valid(res_valid), .res_ready(res_ready), .res_pc(res_pc), .res_sp(res_sp),
    .res_taken(res_taken), .res_cycles(res_cycles),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rdata(rsp_d)
  );

  function automatic logic [7:0] peek(input logic [31:0] a);
    if (smem.exists(a)) return smem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        smem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
      end else begin
        rsp_v <= 1'b1;
        rsp_d <= peek(mem_req_addr);
      end
    end
  end

  always @(negedge clk)
    mem_req_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [3:0] cc, input logic [3:0] f);
    bit s, z, v, c;
    s = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cc)
      4'd0:  return 1'b0;
      4'd1:  return s != v;
      4'd2:  return (s != v) || z;
      4'd3:  return c || z;
      4'd4:  return v;
      4'd5:  return s;
      4'd6:  return z;
      4'd7:  return c;
      4'd8:  return 1'b1;
      4'd9:  return s == v;
      4'd10: return (s == v) && !z;
      4'd11: return !c && !z;
      4'd12: return !v;
      4'd13: return !s;
      4'd14: return !z;
      default: return !c;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] k, input logic [3:0] cc, input logic [3:0] fl,
                        input logic [31:0] ea, input logic [31:0] seq, input logic [31:0] sp,
                        input bit hold, input bit stall, input string req);
    bit tk, use_stk;
    int cost, j, wr0;
    logic [31:0] epc, esp;
    tk      = (k != 2'b11) && ref_cond(cc, fl);
    use_stk = tk && (k == 2'b01 || k == 2'b10);
    cost    = !tk ? 6 : (k == 2'b00 ? 9 : 12);
    epc = seq; esp = sp;
    if (tk && k == 2'b00) epc = ea;
    if (tk && k == 2'b01) begin epc = ea; esp = sp - 4; end
    if (tk && k == 2'b10) begin
      epc = {peek(sp + 3), peek(sp + 2), peek(sp + 1), peek(sp)};
      esp = sp + 4;
    end
    wr0 = wr_cnt;
    @(negedge clk);
    chk(op_ready, "R8", "ready when idle", {31'd0, op_ready}, 32'd1);
    op_kind = k; op_cc = cc; op_flags = fl; op_ea = ea; op_seq_pc = seq; op_sp = sp;
    op_valid = 1'b1; res_ready = !hold; stall_mode = stall;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    op_ea = ~ea; op_cc = ~cc; op_flags = ~fl; op_sp = ~sp; op_seq_pc = ~seq; op_kind = ~k;
    j = 0;
    forever begin
      if (res_valid) break;
      if (!use_stk) chk(!mem_req_valid, "R4", "stack idle", {31'd0, mem_req_valid}, 32'd0);
      chk(!op_ready, "R8", "ready low busy", {31'd0, op_ready}, 32'd0);
      if (j > 400) begin chk(1'b0, req, "result timeout", j, cost); break; end
      @(negedge clk);
      j++;
    end
    stall_mode = 1'b0;
    if (stall) chk(j >= cost, "R7", "latency floor", j, cost);
    else       chk(j == cost, "R7", "latency exact", j, cost);
    chk(res_pc == epc, req, "pc", res_pc, epc);
    chk(res_sp == esp, req, "sp", res_sp, esp);
    chk(res_taken == tk, req, "taken", {31'd0, res_taken}, {31'd0, tk});
    chk(res_cycles == 4'(cost), req, "cycles", {28'd0, res_cycles}, cost);
    if (hold) begin
      repeat (4) begin
        @(negedge clk);
        chk(res_valid && res_pc == epc && res_sp == esp && res_cycles == 4'(cost),
            "R9", "held result", res_pc, epc);
      end
      res_ready = 1'b1;
    end
    @(negedge clk);
    chk(!res_valid && op_ready, "R8", "release", {30'd0, res_valid, op_ready}, 32'd1);
    if (tk && k == 2'b01) begin
      chk(wr_cnt - wr0 == 4, "R5", "write count", wr_cnt - wr0, 4);
      for (int b = 0; b < 4; b++)
        chk(peek(sp - 4 + b) == seq[8*b +: 8], "R5", "stored byte", peek(sp - 4 + b), seq[8*b +: 8]);
    end else begin
      chk(wr_cnt == wr0, use_stk ? "R6" : "R4", "no writes", wr_cnt - wr0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) smem[32'h0000_3000 + i] = 8'(8'hA0 + i);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(op_ready && !res_valid && !mem_req_valid, "R1", "in reset",
        {29'd0, op_ready, res_valid, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready && !res_valid && !mem_req_valid, "R1", "after reset",
        {29'd0, op_ready, res_valid, mem_req_valid}, 32'd4);

    // R3 taken jump, R4 not-taken jump
    run_op(2'b00, 4'h8, 4'h0, 32'h1234_5678, 32'h0000_0100, 32'h0000_8000, 0, 0, "R3");
    run_op(2'b00, 4'h0, 4'hF, 32'h1234_5678, 32'h0000_0104, 32'h0000_8000, 0, 0, "R4");

    // R2 full condition sweep on jumps
    for (int cc = 0; cc < 16; cc++) begin
      for (int p = 0; p < 6; p++) begin
        logic [3:0] fl;
        case (p)
          0: fl = 4'h0; 1: fl = 4'hF; 2: fl = 4'hA;
          3: fl = 4'h5; 4: fl = 4'h4; default: fl = 4'h9;
        endcase
        run_op(2'b00, 4'(cc), fl, 32'h4000_0000 + 32'(cc * 16 + p), 32'h0000_0200, 32'h8000, 0, 0, "R2");
      end
    end

    // R5 call then R6 return of the same address
    run_op(2'b01, 4'hE, 4'h0, 32'h00AB_CDE0, 32'hDEAD_BEEF, 32'h0000_8000, 0, 0, "R5");
    run_op(2'b10, 4'hF, 4'h0, 32'h0, 32'h0000_0300, 32'h0000_7FFC, 0, 0, "R6");
    // R6 return from preloaded bytes
    run_op(2'b10, 4'h8, 4'h0, 32'h0, 32'h0000_0304, 32'h0000_3000, 0, 0, "R6");

    // R4 not-taken call and return
    run_op(2'b01, 4'h6, 4'h0, 32'h5555_0000, 32'h0000_0400, 32'h0000_9000, 0, 0, "R4");
    run_op(2'b10, 4'h7, 4'h0, 32'h5555_0000, 32'h0000_0404, 32'h0000_3000, 0, 0, "R4");

    // R11 reserved code never taken
    run_op(2'b11, 4'h8, 4'hF, 32'h7777_0000, 32'h0000_0500, 32'h0000_9000, 0, 0, "R11");

    // R9 result held under back-pressure
    run_op(2'b00, 4'h8, 4'h0, 32'h0BAD_F00D, 32'h0000_0600, 32'h9000, 1, 0, "R9");
    run_op(2'b01, 4'h8, 4'h0, 32'h0C0F_FEE0, 32'h1357_9BDF, 32'hA000, 1, 0, "R9");

    // R7 / R10 stack stalls: budget versus last byte
    for (int n = 0; n < 12; n++) begin
      logic [31:0] ret;
      ret = 32'h2468_0000 + 32'(n * 32'h0101_0101);
      run_op(2'b01, 4'hB, 4'h0, 32'h0000_1000 + 32'(n), ret, 32'h0000_C000 + 32'(n * 8), 0, 1, "R10");
      run_op(2'b10, 4'h8, 4'h0, 32'h0, 32'h0000_0700, 32'h0000_BFFC + 32'(n * 8), 0, 1, "R10");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule